// File: doc/BRIEF.md
# Byte-Addressed Program Counter with Latched Upper Bytes

This block holds the 21-bit byte address of the next instruction fetch. Instruction words are two bytes wide, so the counter moves in steps of two and its bit 0 always reads as zero. Only the low byte of the counter is reachable as an ordinary data register. The middle and upper bytes are staged through two latch registers. Writing the low byte, directly or by adding an offset to it, loads the whole counter at once from the upper latch, the middle latch and the new low byte.

The latches are not kept up to date on their own. They change only when they are written explicitly, or when the low byte is read. A read of the low byte copies the counter's current middle and upper bytes into the latches. This is what makes a computed jump into a lookup table work. The caller loads the working register with a byte offset into the table. It then calls a routine whose first action adds that offset to the low byte. Execution lands on one of a run of return-with-literal words. Each of these pops the return stack and hands its constant back, and the block captures that constant.

Calls push the address of the following instruction onto a return stack of configurable depth, and returns pop it. Pushing onto a full stack and popping an empty one each raise a sticky flag.

Top module: `prog_counter`

## Requirements
- R1: After reset, the counter, both latches, the stack level, both stack flags and the captured literal are all zero.
- R2: Command 1 (step) adds 2 to the counter. Command 0 (hold) leaves the counter unchanged.
- R3: Command 2 (jump) loads the counter from the target input with bit 0 cleared.
- R4: Command 3 (add-low) sets the counter to {upper latch, middle latch, (low byte + working register) mod 256} with bit 0 cleared. There is no carry into the middle byte, and the latches are not changed.
- R5: Command 4 (write-low) sets the counter to {upper latch, middle latch, working register} with bit 0 cleared.
- R6: The low-byte read output always equals counter bits 7:0. When the read strobe is high, on the next cycle the upper latch holds the old counter bits 20:16 and the middle latch holds the old bits 15:8. An explicit write to a latch in the same cycle takes precedence for that latch.
- R7: The upper-latch write enable loads latch data bits 4:0, and the middle-latch write enable loads all 8 latch data bits. Without a write or a read, the latches hold their values under every command.
- R8: Command 5 (call) pushes counter+2, jumps to the target with bit 0 cleared, and raises the stack level by one.
- R9: Commands 6 (return) and 7 (return-with-literal) load the counter from the most recent push and lower the level by one. Command 7 also captures the literal input. No other command changes the captured literal.
- R10: A call with the stack full sets the sticky overflow flag. It leaves the level and the stored entries unchanged, and it still jumps.
- R11: A return with the stack empty sets the sticky underflow flag, loads the counter with zero and leaves the level at zero.
- R12: Counter bit 0 is zero in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op | input | 3 | Command code, 0 to 7 as listed in the requirements |
| jmp_tgt | input | PC_W | Target address for jump and call |
| wreg | input | 8 | Working-register value for add-low and write-low |
| lit_in | input | 8 | Literal returned by command 7 |
| lo_rd | input | 1 | Low-byte read strobe; refreshes the latches |
| hi_we | input | 1 | Upper-latch write enable |
| mid_we | input | 1 | Middle-latch write enable |
| latch_wdata | input | 8 | Data for latch writes |
| lo_rdata | output | 8 | Counter low byte |
| pc | output | PC_W | Counter value |
| hi_latch | output | PC_W-16 | Upper latch |
| mid_latch | output | 8 | Middle latch |
| ret_byte | output | 8 | Last captured return literal |
| stk_level | output | clog2(STK_DEPTH+1) | Entries on the return stack |
| stk_ovf | output | 1 | Sticky push-on-full flag |
| stk_unf | output | 1 | Sticky pop-on-empty flag |

## Verification
A low-byte read can fall in the same cycle as an explicit latch write, and either can share a cycle with an add-low or write-low command that consumes the latches. The bench provokes these coincidences in two ways: with directed cycles that pair a read with a middle-latch write, and with random strobes layered over every command. A bench model judges each case. In the model, the write beats the refresh for that latch, and the counter is built from the latch values held before the edge.

// File: rtl/prog_counter_pkg.sv
package prog_counter_pkg;
    typedef enum logic [2:0] {
        OP_HOLD   = 3'd0,
        OP_STEP   = 3'd1,
        OP_JUMP   = 3'd2,
        OP_ADDLO  = 3'd3,
        OP_WRLO   = 3'd4,
        OP_CALL   = 3'd5,
        OP_RET    = 3'd6,
        OP_RETLIT = 3'd7
    } pc_op_e;
endpackage

// File: rtl/pc_next_calc.sv
module pc_next_calc #(
    parameter int PC_W = 21
) (
    input  logic [2:0]       op,
    input  logic [PC_W-1:0]  pc_q,
    input  logic [PC_W-1:0]  tgt,
    input  logic [7:0]       wreg,
    input  logic [PC_W-17:0] hi_q,
    input  logic [7:0]       mid_q,
    input  logic [PC_W-1:0]  top_val,
    input  logic             stk_empty,
    output logic [PC_W-1:0]  pc_d,
    output logic [PC_W-1:0]  push_val,
    output logic             push,
    output logic             pop,
    output logic             cap_lit
);
    import prog_counter_pkg::*;

    logic [PC_W-1:0] raw_d;
    logic [7:0]      low_sum;

    always_comb begin
        low_sum  = pc_q[7:0] + wreg;
        push_val = pc_q + PC_W'(2);
        raw_d    = pc_q;
        push     = 1'b0;
        pop      = 1'b0;
        cap_lit  = 1'b0;
        case (pc_op_e'(op))
            OP_STEP:  raw_d = pc_q + PC_W'(2);
            OP_JUMP:  raw_d = tgt;
            OP_ADDLO: raw_d = {hi_q, mid_q, low_sum};
            OP_WRLO:  raw_d = {hi_q, mid_q, wreg};
            OP_CALL: begin
                push  = 1'b1;
                raw_d = tgt;
            end
            OP_RET, OP_RETLIT: begin
                pop     = 1'b1;
                cap_lit = (pc_op_e'(op) == OP_RETLIT);
                raw_d   = stk_empty ? '0 : top_val;
            end
            default: raw_d = pc_q;
        endcase
        pc_d = {raw_d[PC_W-1:1], 1'b0};
    end
endmodule

// File: rtl/pc_latch_bank.sv
module pc_latch_bank #(
    parameter int PC_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lo_rd,
    input  logic [PC_W-1:8]  pc_hi_bits,
    input  logic             hi_we,
    input  logic             mid_we,
    input  logic [7:0]       wdata,
    output logic [PC_W-17:0] hi_q,
    output logic [7:0]       mid_q
);
    typedef struct packed {
        logic [PC_W-17:0] hi;
        logic [7:0]       mid;
    } latch_st_t;

    latch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lo_rd) begin
            st_d.hi  = pc_hi_bits[PC_W-1:16];
            st_d.mid = pc_hi_bits[15:8];
        end
        if (hi_we)  st_d.hi  = wdata[PC_W-17:0];
        if (mid_we) st_d.mid = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hi_q  = st_q.hi;
    assign mid_q = st_q.mid;
endmodule

// File: rtl/pc_ret_stack.sv
module pc_ret_stack #(
    parameter int PC_W  = 21,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  logic [PC_W-1:0]            push_val,
    output logic [PC_W-1:0]            top_val,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       ovf,
    output logic                       unf
);
    localparam int SP_W  = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [SP_W-1:0] sp;
        logic            ovf;
        logic            unf;
    } stk_st_t;

    stk_st_t          st_d, st_q;
    logic [PC_W-1:0]  mem_q [DEPTH];
    logic             full;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;

    always_comb begin
        full   = (st_q.sp == SP_W'(DEPTH));
        empty  = (st_q.sp == '0);
        wr_idx = IDX_W'(st_q.sp);
        rd_idx = IDX_W'(st_q.sp - SP_W'(1));
        wr_en  = push && !full;
        st_d   = st_q;
        if (push) begin
            if (full) st_d.ovf = 1'b1;
            else      st_d.sp  = st_q.sp + SP_W'(1);
        end
        if (pop) begin
            if (empty) st_d.unf = 1'b1;
            else       st_d.sp  = st_q.sp - SP_W'(1);
        end
        top_val = empty ? '0 : mem_q[rd_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_idx] <= push_val;
        end
    end

    assign level = st_q.sp;
    assign ovf   = st_q.ovf;
    assign unf   = st_q.unf;
endmodule

// File: rtl/prog_counter.sv
module prog_counter #(
    parameter int PC_W      = 21,
    parameter int STK_DEPTH = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [2:0]                     op,
    input  logic [PC_W-1:0]                jmp_tgt,
    input  logic [7:0]                     wreg,
    input  logic [7:0]                     lit_in,
    input  logic                           lo_rd,
    input  logic                           hi_we,
    input  logic                           mid_we,
    input  logic [7:0]                     latch_wdata,
    output logic [7:0]                     lo_rdata,
    output logic [PC_W-1:0]                pc,
    output logic [PC_W-17:0]               hi_latch,
    output logic [7:0]                     mid_latch,
    output logic [7:0]                     ret_byte,
    output logic [$clog2(STK_DEPTH+1)-1:0] stk_level,
    output logic                           stk_ovf,
    output logic                           stk_unf
);
    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [7:0]      ret_byte;
    } core_st_t;

    core_st_t        st_d, st_q;
    logic [PC_W-1:0] pc_nxt;
    logic [PC_W-1:0] push_val;
    logic [PC_W-1:0] top_val;
    logic            push;
    logic            pop;
    logic            cap_lit;
    logic            stk_empty;

    pc_next_calc #(.PC_W(PC_W)) i_next (
        .op        (op),
        .pc_q      (st_q.pc),
        .tgt       (jmp_tgt),
        .wreg      (wreg),
        .hi_q      (hi_latch),
        .mid_q     (mid_latch),
        .top_val   (top_val),
        .stk_empty (stk_empty),
        .pc_d      (pc_nxt),
        .push_val  (push_val),
        .push      (push),
        .pop       (pop),
        .cap_lit   (cap_lit)
    );

    pc_latch_bank #(.PC_W(PC_W)) i_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .lo_rd      (lo_rd),
        .pc_hi_bits (st_q.pc[PC_W-1:8]),
        .hi_we      (hi_we),
        .mid_we     (mid_we),
        .wdata      (latch_wdata),
        .hi_q       (hi_latch),
        .mid_q      (mid_latch)
    );

    pc_ret_stack #(.PC_W(PC_W), .DEPTH(STK_DEPTH)) i_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .push_val (push_val),
        .top_val  (top_val),
        .empty    (stk_empty),
        .level    (stk_level),
        .ovf      (stk_ovf),
        .unf      (stk_unf)
    );

    always_comb begin
        st_d    = st_q;
        st_d.pc = pc_nxt;
        if (cap_lit) st_d.ret_byte = lit_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc       = st_q.pc;
    assign ret_byte = st_q.ret_byte;
    assign lo_rdata = st_q.pc[7:0];
endmodule

// File: rtl/prog_counter_chk.sv
module prog_counter_chk #(
    parameter int PC_W      = 21,
    parameter int STK_DEPTH = 8
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [2:0]                     op,
    input logic [PC_W-1:0]                jmp_tgt,
    input logic                           lo_rd,
    input logic                           hi_we,
    input logic                           mid_we,
    input logic [7:0]                     lo_rdata,
    input logic [PC_W-1:0]                pc,
    input logic [PC_W-17:0]               hi_latch,
    input logic [7:0]                     mid_latch,
    input logic [7:0]                     ret_byte,
    input logic [$clog2(STK_DEPTH+1)-1:0] stk_level,
    input logic                           stk_ovf,
    input logic                           stk_unf
);
    localparam int SP_W = $clog2(STK_DEPTH + 1);

    // R2
    step_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd1) |=> (pc == $past(pc) + PC_W'(2)));

    // R3
    jump_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd2) |=> (pc == {$past(jmp_tgt[PC_W-1:1]), 1'b0}));

    // R4
    addlo_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd3) |=> (pc[PC_W-1:8] == $past({hi_latch, mid_latch})));

    // R6
    rd_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_rd && !hi_we && !mid_we) |=> ({hi_latch, mid_latch} == $past(pc[PC_W-1:8])));

    // R6
    rd_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_rdata == pc[7:0]);

    // R9
    lit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op != 3'd7) |=> $stable(ret_byte));

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd5 && stk_level == SP_W'(STK_DEPTH)) |=> (stk_ovf && $stable(stk_level)));

    // R11
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op[2:1] == 2'b11 && stk_level == '0) |=> (stk_unf && pc == '0));

    // R12
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc[0] == 1'b0);
endmodule

bind prog_counter prog_counter_chk #(.PC_W(PC_W), .STK_DEPTH(STK_DEPTH)) i_prog_counter_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .jmp_tgt   (jmp_tgt),
    .lo_rd     (lo_rd),
    .hi_we     (hi_we),
    .mid_we    (mid_we),
    .lo_rdata  (lo_rdata),
    .pc        (pc),
    .hi_latch  (hi_latch),
    .mid_latch (mid_latch),
    .ret_byte  (ret_byte),
    .stk_level (stk_level),
    .stk_ovf   (stk_ovf),
    .stk_unf   (stk_unf)
);

// File: tb/test_prog_counter.sv
`timescale 1ns/1ps
module test_prog_counter;
    localparam int PC_W  = 21;
    localparam int DEPTH = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2:0]      op = '0;
    logic [PC_W-1:0] jmp_tgt = '0;
    logic [7:0]      wreg = '0;
    logic [7:0]      lit_in = '0;
    logic            lo_rd = 1'b0;
    logic            hi_we = 1'b0;
    logic            mid_we = 1'b0;
    logic [7:0]      latch_wdata = '0;
    logic [7:0]      lo_rdata;
    logic [PC_W-1:0] pc;
    logic [4:0]      hi_latch;
    logic [7:0]      mid_latch;
    logic [7:0]      ret_byte;
    logic [3:0]      stk_level;
    logic            stk_ovf;
    logic            stk_unf;

    int n_checks = 0;
    int n_fails  = 0;

    logic [PC_W-1:0] m_pc;
    logic [4:0]      m_hi;
    logic [7:0]      m_mid;
    logic [7:0]      m_ret;
    int              m_lvl;
    logic            m_ovf;
    logic            m_unf;
    logic [PC_W-1:0] m_stk [16];

    always #4 clk = ~clk;

    prog_counter #(.PC_W(PC_W), .STK_DEPTH(DEPTH)) i_prog_counter (
        .clk(clk), .rst_n(rst_n), .op(op), .jmp_tgt(jmp_tgt), .wreg(wreg),
        .lit_in(lit_in), .lo_rd(lo_rd), .hi_we(hi_we), .mid_we(mid_we),
        .latch_wdata(latch_wdata), .lo_rdata(lo_rdata), .pc(pc),
        .hi_latch(hi_latch), .mid_latch(mid_latch), .ret_byte(ret_byte),
        .stk_level(stk_level), .stk_ovf(stk_ovf), .stk_unf(stk_unf)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] o);
        case (o)
            3'd0, 3'd1: return "R2";
            3'd2:       return "R3";
            3'd3:       return "R4";
            3'd4:       return "R5";
            3'd5:       return "R8";
            default:    return "R9";
        endcase
    endfunction

    task automatic model_apply();
        logic [PC_W-1:0] seq;
        logic [PC_W-1:0] n_pc;
        logic [7:0]      s;
        seq  = m_pc + 21'd2;
        n_pc = m_pc;
        case (op)
            3'd1: n_pc = seq;
            3'd2: n_pc = jmp_tgt;
            3'd3: begin s = m_pc[7:0] + wreg; n_pc = {m_hi, m_mid, s}; end
            3'd4: n_pc = {m_hi, m_mid, wreg};
            3'd5: begin
                if (m_lvl == DEPTH) m_ovf = 1'b1;
                else begin m_stk[m_lvl] = seq; m_lvl++; end
                n_pc = jmp_tgt;
            end
            3'd6, 3'd7: begin
                if (m_lvl == 0) begin m_unf = 1'b1; n_pc = '0; end
                else begin m_lvl--; n_pc = m_stk[m_lvl]; end
                if (op == 3'd7) m_ret = lit_in;
            end
            default: n_pc = m_pc;
        endcase
        n_pc[0] = 1'b0;
        if (lo_rd) begin m_hi = m_pc[20:16]; m_mid = m_pc[15:8]; end
        if (hi_we)  m_hi  = latch_wdata[4:0];
        if (mid_we) m_mid = latch_wdata;
        m_pc = n_pc;
    endtask

    task automatic compare_all(input string req);
        chk(pc == m_pc, req, "pc", pc, m_pc);
        chk(pc[0] == 1'b0, "R12", "pc bit0", pc[0], 0);
        chk(hi_latch == m_hi, "R7", "upper latch", hi_latch, m_hi);
        chk(mid_latch == m_mid, "R7", "middle latch", mid_latch, m_mid);
        chk(int'(stk_level) == m_lvl, req, "stack level", stk_level, m_lvl);
        chk(stk_ovf == m_ovf, "R10", "overflow flag", stk_ovf, m_ovf);
        chk(stk_unf == m_unf, "R11", "underflow flag", stk_unf, m_unf);
        chk(ret_byte == m_ret, "R9", "return literal", ret_byte, m_ret);
    endtask

    task automatic cyc(input logic [2:0] o, input logic [PC_W-1:0] t, input logic [7:0] w,
                       input logic [7:0] l, input bit rd, input bit hw, input bit mw,
                       input logic [7:0] lwd);
        @(negedge clk);
        op = o; jmp_tgt = t; wreg = w; lit_in = l;
        lo_rd = rd; hi_we = hw; mid_we = mw; latch_wdata = lwd;
        #1;
        chk(lo_rdata == m_pc[7:0], "R6", "low byte view", lo_rdata, m_pc[7:0]);
        model_apply();
        @(posedge clk);
        #2;
        compare_all(req_of(o));
    endtask

    initial begin
        #(8 * 190000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_pc = '0; m_hi = '0; m_mid = '0; m_ret = '0;
        m_lvl = 0; m_ovf = 1'b0; m_unf = 1'b0;
        for (int i = 0; i < 16; i++) m_stk[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(pc == '0, "R1", "pc", pc, 0);
        chk(hi_latch == '0 && mid_latch == '0, "R1", "latches", {hi_latch, mid_latch}, 0);
        chk(stk_level == '0 && !stk_ovf && !stk_unf, "R1", "stack", stk_level, 0);
        chk(ret_byte == '0, "R1", "literal", ret_byte, 0);

        // R2: step and hold
        cyc(3'd1, '0, 8'h00, 8'h00, 0, 0, 0, 8'h00);
        cyc(3'd1, '0, 8'h00, 8'h00, 0, 0, 0, 8'h00);
        cyc(3'd0, '0, 8'h00, 8'h00, 0, 0, 0, 8'h00);
        chk(pc == 21'h4, "R2", "after two steps", pc, 21'h4);
        // R3: jump with odd target
        cyc(3'd2, 21'h1ABCD1, 8'h00, 8'h00, 0, 0, 0, 8'h00);
        chk(pc == 21'h1ABCD0, "R3", "jump", pc, 21'h1ABCD0);
        // R6: read refreshes latches
        cyc(3'd0, '0, 8'h00, 8'h00, 1, 0, 0, 8'h00);
        chk(hi_latch == 5'h1A && mid_latch == 8'hBC, "R6", "refresh", {hi_latch, mid_latch}, 13'h1ABC);
        // R6: read with middle write, write wins
        cyc(3'd1, '0, 8'h00, 8'h00, 1, 0, 1, 8'h77);
        chk(mid_latch == 8'h77 && hi_latch == 5'h1A, "R6", "write beats refresh", mid_latch, 8'h77);
        // R7: explicit latch writes, then R5 write-low
        cyc(3'd0, '0, 8'h00, 8'h00, 0, 1, 1, 8'hE3);
        cyc(3'd4, '0, 8'h21, 8'h00, 0, 0, 0, 8'h00);
        chk(pc == 21'h03E320, "R5", "write-low", pc, 21'h03E320);
        // R4: add-low wraps without carry and takes latches
        cyc(3'd2, 21'h0012F0, 8'h00, 8'h00, 0, 0, 0, 8'h00);
        cyc(3'd3, '0, 8'h20, 8'h00, 0, 0, 0, 8'h00);
        chk(pc == 21'h03E310, "R4", "add-low wrap", pc, 21'h03E310);
        // R8, R9: computed table call and literal return
        cyc(3'd5, 21'h000100, 8'h00, 8'h00, 0, 0, 0, 8'h00);
        chk(stk_level == 4'd1, "R8", "level after call", stk_level, 1);
        cyc(3'd7, '0, 8'h00, 8'h5A, 0, 0, 0, 8'h00);
        chk(pc == 21'h03E312 && ret_byte == 8'h5A, "R9", "return", pc, 21'h03E312);
        // R11: underflow
        cyc(3'd6, '0, 8'h00, 8'h00, 0, 0, 0, 8'h00);
        chk(stk_unf && pc == '0, "R11", "underflow", pc, 0);
        // R10: overflow
        for (int i = 0; i < DEPTH + 1; i++) cyc(3'd5, 21'(i * 64), 8'h00, 8'h00, 0, 0, 0, 8'h00);
        chk(stk_ovf && stk_level == 4'(DEPTH), "R10", "overflow", stk_level, DEPTH);
        for (int i = 0; i < DEPTH; i++) cyc(3'd6, '0, 8'h00, 8'h00, 0, 0, 0, 8'h00);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] o;
            int r;
            r = int'($urandom % 100);
            o = (r < 30) ? 3'd1 : 3'($urandom % 8);
            cyc(o, 21'($urandom), 8'($urandom), 8'($urandom),
                ($urandom % 4) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0, 8'($urandom));
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule